// File: doc/BRIEF.md
# Spare-Row Remapping Address Decoder

This block sits in the row-address path of a memory array that is built with a few more physical rows than its rated capacity. A small bank of one-time-programmable repair entries records which logical rows are defective. Each entry names one faulty logical row and the spare row that replaces it. On every access the incoming logical row is compared with all valid entries at once. On a match the access is steered to the assigned spare row. On a miss the row passes through unchanged. Either way the host sees a defect-free memory of the rated size, and the lookup adds no cycle of latency.

A faulty row is never partly used: it is replaced as a whole. Entries are written through a program port. An entry accepts exactly one write and behaves like a blown fuse from then on. The physical row bus has one more bit than the logical row. Its top bit selects the spare region, and its low bits then carry the spare index. Because of this layout, the number of spares changes no port width. A status output reports how many spares are in use, whether all of them are taken, and whether two entries were ever programmed for the same faulty row.

Top module: `spare_row_remap`

## Requirements
- R1: After reset no entry is valid, `spares_used` is 0, `exhausted` is 0 and `conflict` is 0.
- R2: When no valid entry holds `row_in`, `phys_row` equals `{1'b0, row_in}` and `remap_hit` is 0 in the same cycle.
- R3: When a valid entry holds `row_in`, `phys_row` equals `{1'b1, spare}`, where `spare` is that entry's spare index, and `remap_hit` is 1. This happens combinationally in the same cycle.
- R4: A program request is accepted if `prog_en` is 1, `prog_sel` < N_SPARE, `prog_spare` < N_SPARE, and the selected entry is not yet valid. The entry then becomes valid with row `prog_row` and spare `prog_spare`, and it takes effect from the next clock edge.
- R5: Once an entry is valid, it ignores any further program request aimed at it. Its row and spare index keep their values.
- R6: A program request with `prog_sel` >= N_SPARE or `prog_spare` >= N_SPARE changes no entry.
- R7: When several valid entries hold the same row, the entry with the lowest number supplies the spare index.
- R8: `conflict` becomes 1 on the clock edge that accepts a request whose `prog_row` is already held by a valid entry. It stays 1 until reset.
- R9: `spares_used` equals the number of valid entries. `exhausted` is 1 exactly when that number equals N_SPARE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all entries |
| row_in | input | ROW_W | Logical row of the current access |
| phys_row | output | ROW_W+1 | Physical row: MSB set selects the spare region |
| remap_hit | output | 1 | Current access was redirected to a spare |
| prog_en | input | 1 | Program request |
| prog_sel | input | ROW_W | Repair entry number to program |
| prog_row | input | ROW_W | Faulty logical row recorded in the entry |
| prog_spare | input | ROW_W | Spare index assigned to the entry |
| spares_used | output | ROW_W+1 | Number of valid entries |
| exhausted | output | 1 | Every spare is assigned |
| conflict | output | 1 | Sticky: a row was programmed into two entries |

## Verification
The hardest case to reach is the priority rule. It can only be seen when two valid entries hold the same row, and the port rejects writes to a valid entry. So the bench programs a higher-numbered entry first and then the lower-numbered one with the same row. The lookup must then switch to the later entry's spare, and the conflict flag must rise on that edge. The bench also tries to rewrite a valid entry and to use out-of-range selectors and spare indices. It then sweeps every row, so that any disturbed mapping shows up at `phys_row`.

// File: rtl/spare_row_remap.sv
module spare_row_remap #(
  parameter int ROW_W   = 6,
  parameter int N_SPARE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row_in,
  output logic [ROW_W:0]   phys_row,
  output logic             remap_hit,
  input  logic             prog_en,
  input  logic [ROW_W-1:0] prog_sel,
  input  logic [ROW_W-1:0] prog_row,
  input  logic [ROW_W-1:0] prog_spare,
  output logic [ROW_W:0]   spares_used,
  output logic             exhausted,
  output logic             conflict
);
  localparam logic [ROW_W:0] LIMIT = (ROW_W+1)'(N_SPARE);

  logic [N_SPARE-1:0] vld_q;
  logic [ROW_W-1:0]   row_q [N_SPARE];
  logic [ROW_W-1:0]   spr_q [N_SPARE];
  logic [N_SPARE-1:0] wr, look_m, prog_m;
  logic               spare_ok;

  assign spare_ok = {1'b0, prog_spare} < LIMIT;

  for (genvar i = 0; i < N_SPARE; i++) begin : g_ent
    assign wr[i]     = prog_en && spare_ok && !vld_q[i] && prog_sel == ROW_W'(i);
    assign look_m[i] = vld_q[i] && row_q[i] == row_in;
    assign prog_m[i] = vld_q[i] && row_q[i] == prog_row;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        row_q[i] <= '0;
        spr_q[i] <= '0;
      end else if (wr[i]) begin
        vld_q[i] <= 1'b1;
        row_q[i] <= prog_row;
        spr_q[i] <= prog_spare;
      end
    end

    a_r5_fuse_locked: assert property (@(posedge clk) disable iff (!rst_n)
      $past(vld_q[i]) |-> vld_q[i] && $stable(row_q[i]) && $stable(spr_q[i]));
  end

  always_comb begin
    remap_hit = 1'b0;
    phys_row  = {1'b0, row_in};
    for (int i = N_SPARE-1; i >= 0; i--) begin
      if (look_m[i]) begin
        remap_hit = 1'b1;
        phys_row  = {1'b1, spr_q[i]};
      end
    end
  end

  always_comb begin
    spares_used = '0;
    for (int i = 0; i < N_SPARE; i++)
      spares_used = spares_used + (ROW_W+1)'(vld_q[i]);
  end

  assign exhausted = spares_used == LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conflict <= 1'b0;
    else if (|wr && |prog_m) conflict <= 1'b1;
  end

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_hit |-> phys_row == {1'b0, row_in});
  a_r8_conflict_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(conflict));
  a_r9_exhausted_count: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> spares_used == LIMIT);
  a_r9_used_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    spares_used >= $past(spares_used));
endmodule

// File: tb/spare_row_remap_tb_top.sv
`timescale 1ns/1ps
module spare_row_remap_tb_top;
  localparam int ROW_W = 6;
  localparam int N_SPARE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ROW_W-1:0] row_in = '0, prog_sel = '0, prog_row = '0, prog_spare = '0;
  logic prog_en = 1'b0;
  logic [ROW_W:0] phys_row, spares_used;
  logic remap_hit, exhausted, conflict;

  int n_chk = 0, n_err = 0;
  bit m_vld [N_SPARE];
  int m_row [N_SPARE];
  int m_spr [N_SPARE];
  bit m_conf = 0;

  always #4 clk = ~clk;

  spare_row_remap #(.ROW_W(ROW_W), .N_SPARE(N_SPARE)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_in(row_in), .phys_row(phys_row),
    .remap_hit(remap_hit), .prog_en(prog_en), .prog_sel(prog_sel),
    .prog_row(prog_row), .prog_spare(prog_spare), .spares_used(spares_used),
    .exhausted(exhausted), .conflict(conflict));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_lookup(int r);
    for (int i = 0; i < N_SPARE; i++)
      if (m_vld[i] && m_row[i] == r) return (1 << ROW_W) | m_spr[i];
    return r;
  endfunction

  function automatic int m_used();
    int c = 0;
    for (int i = 0; i < N_SPARE; i++) c += m_vld[i];
    return c;
  endfunction

  // inputs already set after a negedge; compare, then apply one edge to the model
  task automatic step(string tag);
    int exp;
    #2;
    exp = m_lookup(int'(row_in));
    chk(tag, int'(phys_row), exp);
    chk(tag, int'(remap_hit), int'(exp >= (1 << ROW_W)));
    chk("R9", int'(spares_used), m_used());
    chk("R9", int'(exhausted), int'(m_used() == N_SPARE));
    chk("R8", int'(conflict), int'(m_conf));
    @(posedge clk);
    if (prog_en && int'(prog_sel) < N_SPARE && int'(prog_spare) < N_SPARE
        && !m_vld[prog_sel]) begin
      for (int i = 0; i < N_SPARE; i++)
        if (m_vld[i] && m_row[i] == int'(prog_row)) m_conf = 1;
      m_vld[prog_sel] = 1;
      m_row[prog_sel] = int'(prog_row);
      m_spr[prog_sel] = int'(prog_spare);
    end
    @(negedge clk);
    prog_en = 1'b0;
  endtask

  task automatic prog(int sel, int r, int sp, int look);
    prog_en = 1'b1; prog_sel = ROW_W'(sel); prog_row = ROW_W'(r);
    prog_spare = ROW_W'(sp); row_in = ROW_W'(look);
    step("R4");
  endtask

  task automatic look(int r, string tag);
    row_in = ROW_W'(r);
    step(tag);
  endtask

  task automatic sweep(string tag);
    for (int r = 0; r < (1 << ROW_W); r++) look(r, tag);
  endtask

  initial begin
    for (int i = 0; i < N_SPARE; i++) begin m_vld[i] = 0; m_row[i] = 0; m_spr[i] = 0; end
    repeat (3) @(negedge clk);
    #2;
    chk("R1", int'(spares_used), 0);
    chk("R1", int'(exhausted), 0);
    chk("R1", int'(conflict), 0);
    chk("R1", int'(remap_hit), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R2");
    prog(0, 10, 1, 10);
    look(10, "R3"); look(11, "R2"); look(9, "R2");
    prog(0, 20, 3, 20);
    look(20, "R5"); look(10, "R5");
    prog(4, 30, 0, 30);
    prog(63, 30, 0, 30);
    prog(2, 30, 4, 30);
    look(30, "R6");
    chk("R6", int'(spares_used), 1);
    prog(2, 9, 0, 9);
    look(9, "R3");
    chk("R8", int'(conflict), 0);
    prog(1, 9, 3, 9);
    look(9, "R7");
    chk("R7", int'(phys_row), (1 << ROW_W) | 3);
    chk("R8", int'(conflict), 1);
    prog(3, 40, 2, 40);
    look(40, "R3");
    chk("R9", int'(exhausted), 1);
    prog(3, 41, 0, 41);
    sweep("R3");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule